// File: doc/BRIEF.md
# Delayed Branch and Call Sequencer

This block steps the program counter of a 32-bit integer core whose instructions all have the same width. It holds two registers: the address of the instruction now being presented (`pc`) and the address that follows it (`npc`). Each cycle the fetch stage presents the word found at `pc`, together with the four integer condition flags. The sequencer decodes calls and integer conditional branches and evaluates the branch condition from the flags. It forms the PC-relative target and advances the pair, so that exactly one delay-slot instruction runs after every control transfer.

A per-branch cancel bit selects whether the delay-slot instruction is annulled. The block reports this to the rest of the pipeline on `slot_annul` while the cancelled word is presented. A format-00 word whose sub-opcode is not defined raises `trap_illegal` in the cycle it is presented. The block only reports the trap and does not redirect the program counter. Constant-load words, arithmetic words and memory words are treated as plain sequential instructions.

The instruction input is a stream with a valid qualifier and no back-pressure. The sequencer takes a presented word at every rising edge where `insn_valid` is high. When `insn_valid` is low, nothing moves. There is no ready signal, so the fetch side never has to wait.

Top module: `delay_slot_sequencer`

## Requirements
- R1: A synchronous reset sets `pc` to 0, `npc` to 4 and `slot_annul` to 0.
- R2: A word that is not a control transfer moves `pc` to the old `npc` and `npc` to the old `npc` + 4. Such words are formats 10 and 11, format 00 with sub-opcode 100, and any branch that is not taken.
- R3: A call (bits [31:30] = 01) moves `pc` to the old `npc` and sets `npc` to the call's own address plus bits [29:0] shifted left by two. It never annuls the delay slot. For example, word 0x40001234 at address 0x2290 targets 0x6B60.
- R4: A format-00 word uses these fields: cancel bit [29], condition [28:25], sub-opcode [24:22] and displacement [21:0]. Sub-opcode 010 is an integer branch. When it is taken, `npc` becomes the branch's address plus the displacement shifted left by two and sign-extended. For example, a displacement of all ones gives −4.
- R5: The low three condition bits select a base test: 0 never, 1 Z, 2 Z or (N xor V), 3 N xor V, 4 C or Z, 5 C, 6 N, 7 V. Condition bit [28] inverts the base test, so 1000 is "always".
- R6: An integer branch with the cancel bit set annuls its delay slot when it is not taken. Condition 1000 with the cancel bit set annuls the slot even though the branch is taken. With the cancel bit clear, the slot always runs.
- R7: Sub-opcodes 110 and 111 are never taken. They raise no trap, and they annul the slot exactly when the cancel bit is set.
- R8: `trap_illegal` is high, combinationally, exactly when a valid, non-annulled format-00 word has sub-opcode 000, 001, 011 or 101. Such a word otherwise sequences as in R2.
- R9: While `slot_annul` is high, the presented word is not decoded: it raises no trap and causes no transfer. The pair advances as in R2 and `slot_annul` clears.
- R10: While `insn_valid` is low, `pc`, `npc` and `slot_annul` hold and `trap_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Presented word is valid this cycle |
| insn | input | 32 | Instruction word fetched from `pc` |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| pc | output | 32 | Address of the presented instruction |
| npc | output | 32 | Address of the instruction after it |
| slot_annul | output | 1 | Presented instruction is cancelled |
| trap_illegal | output | 1 | Presented word has an undefined format-00 sub-opcode |

## Verification
Two of this block's functions can land on the same word.

The first case is a control transfer that sits in the delay slot of another transfer. The bench provokes it by issuing long runs of branches back to back across all sixteen conditions, both cancel-bit values and several flag sets. The second case is an undefined or transfer-type word that arrives in a slot already annulled. The bench provokes it by placing an illegal word and a call directly behind a cancelling branch-never.

A scoreboard model judges each case from the requirements. It checks that the slot's word is neither decoded nor trapped, and that the earlier transfer's target still lands in `npc`.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    CLS_SEQ,
    CLS_CALL,
    CLS_IBR,
    CLS_XBR,
    CLS_ILL
  } xfer_cls_e;

  localparam logic [1:0] FMT_BR   = 2'b00;
  localparam logic [1:0] FMT_CALL = 2'b01;

  localparam logic [2:0] SUB_IBR  = 3'b010;
  localparam logic [2:0] SUB_HI   = 3'b100;
  localparam logic [2:0] SUB_FBR  = 3'b110;
  localparam logic [2:0] SUB_CBR  = 3'b111;

  localparam logic [3:0] COND_ALWAYS = 4'b1000;

  localparam int CALL_DISP_W = 30;
  localparam int BR_DISP_W   = 22;

endpackage

// File: rtl/insn_classify.sv
module insn_classify
  import seq_pkg::*;
(
  input  logic [31:0] word,
  output xfer_cls_e   cls
);

  always_comb begin
    cls = CLS_SEQ;
    if (word[31:30] == FMT_CALL) begin
      cls = CLS_CALL;
    end else if (word[31:30] == FMT_BR) begin
      unique case (word[24:22])
        SUB_IBR:          cls = CLS_IBR;
        SUB_HI:           cls = CLS_SEQ;
        SUB_FBR, SUB_CBR: cls = CLS_XBR;
        default:          cls = CLS_ILL;
      endcase
    end
  end

endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval (
  input  logic [3:0] cond,
  input  logic       fn,
  input  logic       fz,
  input  logic       fc,
  input  logic       fv,
  output logic       taken
);

  logic [7:0] base;

  always_comb begin
    base[0] = 1'b0;
    base[1] = fz;
    base[2] = fz | (fn ^ fv);
    base[3] = fn ^ fv;
    base[4] = fc | fz;
    base[5] = fc;
    base[6] = fn;
    base[7] = fv;
    taken   = base[cond[2:0]] ^ cond[3];
  end

endmodule

// File: rtl/xfer_target.sv
module xfer_target
  import seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] here,
  input  logic [31:0]     word,
  output logic [XLEN-1:0] call_tgt,
  output logic [XLEN-1:0] br_tgt
);

  localparam int CALL_OFF_W = CALL_DISP_W + 2;
  localparam int BR_OFF_W   = BR_DISP_W + 2;

  logic [CALL_OFF_W-1:0]      call_off;
  logic signed [BR_OFF_W-1:0] br_off;

  always_comb begin
    call_off = {word[CALL_DISP_W-1:0], 2'b00};
    br_off   = $signed({word[BR_DISP_W-1:0], 2'b00});
    call_tgt = here + XLEN'(call_off);
    br_tgt   = here + XLEN'(br_off);
  end

endmodule

// File: rtl/delay_slot_sequencer.sv
module delay_slot_sequencer
  import seq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_valid,
  input  logic [31:0]     insn,
  input  logic            flag_n,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_v,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] npc,
  output logic            slot_annul,
  output logic            trap_illegal
);

  localparam logic [XLEN-1:0] STEP    = XLEN'(4);
  localparam logic [XLEN-1:0] PC_INIT = XLEN'(RESET_PC);

  xfer_cls_e       cls;
  logic            taken;
  logic [XLEN-1:0] call_tgt;
  logic [XLEN-1:0] br_tgt;
  logic            live;

  insn_classify u_classify (
    .word (insn),
    .cls  (cls)
  );

  br_cond_eval u_cond (
    .cond  (insn[28:25]),
    .fn    (flag_n),
    .fz    (flag_z),
    .fc    (flag_c),
    .fv    (flag_v),
    .taken (taken)
  );

  xfer_target #(.XLEN(XLEN)) u_target (
    .here     (pc),
    .word     (insn),
    .call_tgt (call_tgt),
    .br_tgt   (br_tgt)
  );

  assign live         = insn_valid & ~slot_annul;
  assign trap_illegal = live & (cls == CLS_ILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= PC_INIT;
      npc        <= PC_INIT + STEP;
      slot_annul <= 1'b0;
    end else if (insn_valid) begin
      pc         <= npc;
      npc        <= npc + STEP;
      slot_annul <= 1'b0;
      if (!slot_annul) begin
        unique case (cls)
          CLS_CALL: npc <= call_tgt;
          CLS_IBR: begin
            if (taken) npc <= br_tgt;
            slot_annul <= insn[29] & (~taken | (insn[28:25] == COND_ALWAYS));
          end
          CLS_XBR: slot_annul <= insn[29];
          default: ;
        endcase
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == PC_INIT && npc == PC_INIT + STEP && !slot_annul)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> ($stable(pc) && $stable(npc) && $stable(slot_annul))); // R10

  AST_TRAP_SCOPE: assert property (@(posedge clk) disable iff (rst)
    trap_illegal |-> (insn_valid && !slot_annul && insn[31:30] == FMT_BR)); // R8

  AST_ANNUL_SKIP: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && slot_annul) |=> (npc == $past(npc) + STEP && !slot_annul)); // R9

  AST_CALL_KEEP_SLOT: assert property (@(posedge clk) disable iff (rst)
    (live && insn[31:30] == FMT_CALL) |=> !slot_annul); // R3

  AST_XBR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (live && insn[31:30] == FMT_BR && insn[24:23] == 2'b11)
      |=> (npc == $past(npc) + STEP && slot_annul == $past(insn[29]))); // R7

endmodule

// File: tb/delay_slot_sequencer_bench.sv
`timescale 1ns/1ps
module delay_slot_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [31:0] insn;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [31:0] pc, npc;
  logic        slot_annul, trap_illegal;

  always #2.5 clk = ~clk;

  delay_slot_sequencer u_delay_slot_sequencer (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .pc(pc), .npc(npc), .slot_annul(slot_annul), .trap_illegal(trap_illegal)
  );

  typedef struct {
    logic [31:0] e_pc;
    logic [31:0] e_npc;
    logic        e_ann;
    int          stamp;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          compared = 0;
  int          mismatched = 0;
  int          cyc = 0;
  bit          finished = 0;
  logic [31:0] m_pc, m_npc;
  logic        m_ann;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cc, v;
    {n, z, cc, v} = f;
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return z | (n ^ v);
      4'd3:  return n ^ v;
      4'd4:  return cc | z;
      4'd5:  return cc;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1'b1;
      4'd9:  return !z;
      4'd10: return !(z | (n ^ v));
      4'd11: return !(n ^ v);
      4'd12: return !(cc | z);
      4'd13: return !cc;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  function automatic logic [31:0] mkbr(input logic a, input logic [3:0] c,
                                       input logic [2:0] sub, input logic [21:0] d);
    return {2'b00, a, c, sub, d};
  endfunction

  function automatic logic [31:0] rom(input logic [31:0] addr);
    case (addr)
      32'h22A8: return 32'h10800003;
      32'h22AC: return 32'h80900009;
      32'h22B0: return 32'h92A26001;
      32'h22B4: return 32'h34BFFFFF;
      32'h22B8: return 32'h90022001;
      default:  return 32'h01000000;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.e_pc = m_pc; e.e_npc = m_npc; e.e_ann = m_ann; e.stamp = cyc; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic issue(input logic [31:0] w, input logic [3:0] f, input string tag);
    logic        exp_trap, tk;
    logic [31:0] nx_npc;
    logic        nx_ann;
    @(negedge clk);
    rst = 1'b0; insn = w; {flag_n, flag_z, flag_c, flag_v} = f; insn_valid = 1'b1;
    #1;
    exp_trap = !m_ann && w[31:30] == 2'b00 &&
               (w[24:22] == 3'b000 || w[24:22] == 3'b001 ||
                w[24:22] == 3'b011 || w[24:22] == 3'b101);
    check(trap_illegal == exp_trap, tag, "trap_illegal", 32'(trap_illegal), 32'(exp_trap));
    nx_npc = m_npc + 32'd4;
    nx_ann = 1'b0;
    if (!m_ann) begin
      if (w[31:30] == 2'b01) begin
        nx_npc = m_pc + {w[29:0], 2'b00};
      end else if (w[31:30] == 2'b00 && w[24:22] == 3'b010) begin
        tk = cond_ok(w[28:25], f);
        if (tk) nx_npc = m_pc + {{8{w[21]}}, w[21:0], 2'b00};
        nx_ann = w[29] && (!tk || w[28:25] == 4'b1000);
      end else if (w[31:30] == 2'b00 && w[24:23] == 2'b11) begin
        nx_ann = w[29];
      end
    end
    m_pc = m_npc; m_npc = nx_npc; m_ann = nx_ann;
    push(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    insn_valid = 1'b0; insn = 32'h0000_0000; rst = 1'b0;
    #1;
    check(trap_illegal == 1'b0, tag, "trap_idle", 32'(trap_illegal), 32'h0);
    push(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        check(pc == e.e_pc, e.tag, "pc", pc, e.e_pc);
        check(npc == e.e_npc, e.tag, "npc", npc, e.e_npc);
        check(slot_annul == e.e_ann, e.tag, "slot_annul", 32'(slot_annul), 32'(e.e_ann));
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    rst = 1'b1; insn_valid = 1'b0; insn = 32'h0;
    {flag_n, flag_z, flag_c, flag_v} = 4'h0;
    m_pc = 32'h0; m_npc = 32'h4; m_ann = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(pc == 32'h0, "R1", "pc_reset", pc, 32'h0);
    check(npc == 32'h4, "R1", "npc_reset", npc, 32'h4);
    check(slot_annul == 1'b0, "R1", "annul_reset", 32'(slot_annul), 32'h0);

    // R3: call from 0 into the loop at 0x22A8, then its delay slot
    issue(32'h400008AA, 4'h0, "R3_call");
    issue(rom(m_pc), 4'h0, "R2_slot");
    // R4 R5 R6: loop replay; first taken, then Z ends it
    for (int k = 0; k < 14; k++)
      issue(rom(m_pc), (k < 9) ? 4'b0000 : 4'b0100, "R4_loop");
    // R10: idle holds state
    idle("R10_idle"); idle("R10_idle");
    // R3: call with displacement 0x1234
    issue(32'h40001234, 4'h0, "R3_call2");
    issue(32'h01000000, 4'h0, "R2_sethi");
    // R5 R6: all conditions, both cancel values, several flag sets, back to back
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 16; c++)
        for (int fi = 0; fi < 4; fi++)
          issue(mkbr(a[0], c[3:0], 3'b010, 22'd3), 4'(fi * 5), "R5_R6_sweep");
    // R4: negative displacements
    issue(mkbr(1'b0, 4'b1000, 3'b010, 22'h3FFFFF), 4'h0, "R4_neg4");
    issue(32'h01000000, 4'h0, "R2_slot");
    issue(mkbr(1'b0, 4'b1000, 3'b010, 22'h200000), 4'h0, "R4_negmax");
    issue(32'h90022001, 4'h0, "R2_fmt10");
    // R7: floating-point and coprocessor branches
    issue(mkbr(1'b1, 4'b1000, 3'b110, 22'd8), 4'hF, "R7_fbr_a");
    issue(32'h01000000, 4'h0, "R9_slot");
    issue(mkbr(1'b0, 4'b1000, 3'b111, 22'd8), 4'hF, "R7_cbr");
    issue(mkbr(1'b1, 4'b0001, 3'b111, 22'd8), 4'hF, "R7_cbr_a");
    // R8: illegal sub-opcodes
    issue(mkbr(1'b0, 4'b0000, 3'b000, 22'd1), 4'h0, "R8_ill0");
    issue(mkbr(1'b1, 4'b1000, 3'b001, 22'd1), 4'h0, "R8_ill1");
    issue(mkbr(1'b0, 4'b0101, 3'b011, 22'd1), 4'h0, "R8_ill3");
    issue(mkbr(1'b0, 4'b1111, 3'b101, 22'd1), 4'h0, "R8_ill5");
    issue(mkbr(1'b0, 4'b0000, 3'b100, 22'h3FFFFF), 4'h0, "R2_sethi");
    // R9: annulled slot holding an illegal word, then a call
    issue(mkbr(1'b1, 4'b0000, 3'b010, 22'd5), 4'h0, "R6_bn_a");
    issue(mkbr(1'b0, 4'b0000, 3'b000, 22'd1), 4'h0, "R9_ill_annulled");
    issue(mkbr(1'b1, 4'b0000, 3'b010, 22'd5), 4'h0, "R6_bn_a");
    issue(32'h40000100, 4'h0, "R9_call_annulled");
    issue(32'hE0023FEC, 4'h0, "R2_fmt11");
    // R10: annul survives an idle cycle
    issue(mkbr(1'b1, 4'b0001, 3'b010, 22'd5), 4'h0, "R6_be_a_nt");
    idle("R10_idle_annul");
    issue(32'h40000100, 4'h0, "R9_after_idle");
    // R1: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1; insn_valid = 1'b1; insn = 32'h40000100;
    m_pc = 32'h0; m_npc = 32'h4; m_ann = 1'b0;
    push("R1_midrun");
    issue(32'h01000000, 4'h0, "R1_after");
    idle("R10_end");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule